// File: doc/BRIEF.md
# Masked Bus Address Comparator

This block sits beside a processor bus and watches each access without taking part in it. It has several identical match units. Each unit holds its own reference value, bit mask and control word. On every clock edge each enabled unit compares either the bus address or the bus data with its reference. Bits whose mask bit is 1 are ignored. The comparison is qualified by access direction (read, write, or both) and by the bus space the access targets. A hit gives a one-cycle event on the next cycle, sets a sticky status flag and, if the unit allows it, raises the shared interrupt request.

Masking lets one unit cover a whole aligned block of addresses, such as a guard band at the end of a stack. Software programs the units through a small write-only register port and may do so at any time while the bus runs. The block drives nothing back onto the bus, so it never stalls or changes an access.

Top module: `bus_match_monitor`

## Requirements
- R1: After reset, `evt`, `flag` and `irq` are all 0. Every unit's reference, mask and control word is 0, so every unit is disabled.
- R2: A unit hits when `((src ^ ref) & ~mask) == 0`. Bits where the mask is 1 do not matter and bits where it is 0 must be equal.
- R3: `evt[i]` is registered. It is 1 in the cycle after an edge that sampled a hitting access, and 0 in the cycle after an edge that sampled no hit.
- R4: Direction is set by control bit 1 (reads hit) and control bit 2 (writes hit). An access hits only if a strobe it drives has its control bit set. With both bits clear the unit never hits.
- R5: Control bit 3 selects the source. When it is 0 the unit compares `bus_addr`, zero-extended to the value width. When it is 1 the unit compares `bus_data`.
- R6: Control bit 4 is the bus space. An access hits only when `bus_space` equals this bit.
- R7: `flag[i]` is set by a hit and stays set until `flag_clr[i]` is 1 at an edge with no hit. A hit and a clear at the same edge leave the flag set.
- R8: `irq` is 1 exactly when some unit has its flag set and its control bit 5 (interrupt enable) set.
- R9: While control bit 0 (enable) is 0, the unit produces no event and its flag keeps its value, even when `flag_clr` is asserted.
- R10: Register writes use `cfg_reg` codes 0 = reference, 1 = mask, 2 = control; code 3 is ignored. A write applies from the next edge, so an access sampled at the same edge as the write is judged with the old settings.
- R11: Units are independent. A write to unit `cfg_unit` changes only that unit, and each unit hits only on its own settings.
- R12: With reference 0x99FF0, mask 0xF and writes enabled, every write from 0x99FF0 to 0x99FFF gives an event. Writes to 0x99FEF and 0x9A000 do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Observed bus address |
| bus_data | input | DATA_W | Observed bus data |
| bus_rd | input | 1 | Observed read strobe |
| bus_wr | input | 1 | Observed write strobe |
| bus_space | input | 1 | Observed bus-space select |
| cfg_we | input | 1 | Register write strobe |
| cfg_unit | input | UNIT_W | Unit to write |
| cfg_reg | input | 2 | Register code: 0 reference, 1 mask, 2 control |
| cfg_wdata | input | VAL_W | Register write value |
| flag_clr | input | NUM_UNITS | Per-unit flag clear |
| evt | output | NUM_UNITS | Per-unit event pulse |
| flag | output | NUM_UNITS | Per-unit sticky status flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the strobes are clean 0/1 levels sampled once per clock edge. They also assume a unit's settings change only through the register port. The bench meets both by driving every input at the falling edge and by touching the units only with register writes it also applies to its own model. Random traffic picks addresses close to a small pool of reference values, so hits, near-misses, simultaneous clear-and-hit and reconfiguration during traffic all occur often. Directed sequences cover the guard-band sweep, disabled hold and same-edge reprogramming.

// File: rtl/bmm_pkg.sv
// Shared types for the masked bus comparator.
// Assumes a control word of six bits per unit, laid out as unit_ctrl_t.
package bmm_pkg;

    localparam int CTRL_W = 6;

    // Per-unit control word, MSB first (bit 5 .. bit 0)
    typedef struct packed {
        logic irq_en;    // bit 5: flag may raise irq
        logic space;     // bit 4: bus space to match
        logic use_data;  // bit 3: compare data instead of address
        logic on_wr;     // bit 2: writes may hit
        logic on_rd;     // bit 1: reads may hit
        logic enable;    // bit 0: unit active
    } unit_ctrl_t;

    typedef enum logic [1:0] {
        REG_REF  = 2'd0,
        REG_MASK = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } cfg_reg_e;

endpackage

// File: rtl/bmm_cfg_bank.sv
// Register bank for all match units: reference, mask and control per unit.
// Assumes one write per cycle; writes to an out-of-range unit or code 3 are dropped.
module bmm_cfg_bank
    import bmm_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int VAL_W     = 32,
    parameter int UNIT_W    = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [UNIT_W-1:0]                   cfg_unit,
    input  logic [1:0]                          cfg_reg,
    input  logic [VAL_W-1:0]                    cfg_wdata,
    output logic [NUM_UNITS-1:0][VAL_W-1:0]     ref_val,
    output logic [NUM_UNITS-1:0][VAL_W-1:0]     mask_val,
    output unit_ctrl_t [NUM_UNITS-1:0]          ctrl_val
);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic sel;

        // Decode whether this write targets this unit
        always_comb sel = cfg_we && (cfg_unit == UNIT_W'(u));

        // Hold the unit's three registers, updated by decoded writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_val[u]  <= '0;
                mask_val[u] <= '0;
                ctrl_val[u] <= '0;
            end else if (sel) begin
                case (cfg_reg_e'(cfg_reg))
                    REG_REF:  ref_val[u]  <= cfg_wdata;
                    REG_MASK: mask_val[u] <= cfg_wdata;
                    REG_CTRL: ctrl_val[u] <= unit_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/bmm_match_unit.sv
// One match unit: masked compare of address or data against a reference,
// qualified by direction and bus space; registers the event and sticky flag.
// Assumes bus inputs are stable around the sampling edge.
module bmm_match_unit
    import bmm_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int VAL_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic              bus_space,
    input  logic [VAL_W-1:0]  ref_val,
    input  logic [VAL_W-1:0]  mask_val,
    input  unit_ctrl_t        ctrl,
    input  logic              clr,
    output logic              evt,
    output logic              flag
);

    logic [VAL_W-1:0] src;
    logic             hit_value;
    logic             hit_type;
    logic             hit_space;
    logic             hit;

    // Pick the compared source, zero-extended to the value width
    always_comb begin
        if (ctrl.use_data) src = VAL_W'(bus_data);
        else               src = VAL_W'(bus_addr);
    end

    // Masked equality plus direction and space qualifiers
    always_comb begin
        hit_value = ((src ^ ref_val) & ~mask_val) == '0;
        hit_type  = (ctrl.on_rd && bus_rd) || (ctrl.on_wr && bus_wr);
        hit_space = (bus_space == ctrl.space);
        hit       = ctrl.enable && hit_value && hit_type && hit_space;
    end

    // Register the event pulse for the sampled access
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= hit;
    end

    // Sticky flag: hit wins over clear; frozen while disabled
    always_ff @(posedge clk) begin
        if (!rst_n)               flag <= 1'b0;
        else if (ctrl.enable) begin
            if (hit)              flag <= 1'b1;
            else if (clr)         flag <= 1'b0;
        end
    end

endmodule

// File: rtl/bmm_irq_merge.sv
// Combines per-unit flags, each gated by its interrupt enable, into one request.
// Assumes flags and enables are register outputs, so irq is glitch-free.
module bmm_irq_merge
    import bmm_pkg::*;
#(
    parameter int NUM_UNITS = 4
) (
    input  logic [NUM_UNITS-1:0]        flag,
    input  unit_ctrl_t [NUM_UNITS-1:0]  ctrl_val,
    output logic                        irq
);

    logic [NUM_UNITS-1:0] gated;

    // Gate each flag with its unit's interrupt enable
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_gate
        always_comb gated[u] = flag[u] && ctrl_val[u].irq_en;
    end

    // Reduce the gated flags into the request
    always_comb irq = |gated;

endmodule

// File: rtl/bus_match_monitor.sv
// Passive bus monitor with NUM_UNITS masked comparators, a register write port,
// per-unit event pulses and sticky flags, and a shared interrupt request.
// Assumes NUM_UNITS >= 2; it has no outputs toward the bus.
module bus_match_monitor
    import bmm_pkg::*;
#(
    parameter  int NUM_UNITS = 4,
    parameter  int ADDR_W    = 20,
    parameter  int DATA_W    = 32,
    localparam int UNIT_W    = $clog2(NUM_UNITS),
    localparam int VAL_W     = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_data,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic                 bus_space,
    input  logic                 cfg_we,
    input  logic [UNIT_W-1:0]    cfg_unit,
    input  logic [1:0]           cfg_reg,
    input  logic [VAL_W-1:0]     cfg_wdata,
    input  logic [NUM_UNITS-1:0] flag_clr,
    output logic [NUM_UNITS-1:0] evt,
    output logic [NUM_UNITS-1:0] flag,
    output logic                 irq
);

    logic [NUM_UNITS-1:0][VAL_W-1:0] ref_val;
    logic [NUM_UNITS-1:0][VAL_W-1:0] mask_val;
    unit_ctrl_t [NUM_UNITS-1:0]      ctrl_val;
    logic [NUM_UNITS-1:0]            unit_en;

    bmm_cfg_bank #(
        .NUM_UNITS (NUM_UNITS),
        .VAL_W     (VAL_W),
        .UNIT_W    (UNIT_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_unit  (cfg_unit),
        .cfg_reg   (cfg_reg),
        .cfg_wdata (cfg_wdata),
        .ref_val   (ref_val),
        .mask_val  (mask_val),
        .ctrl_val  (ctrl_val)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        // Expose each unit's enable for the checker
        always_comb unit_en[u] = ctrl_val[u].enable;

        bmm_match_unit #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .VAL_W  (VAL_W)
        ) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_addr  (bus_addr),
            .bus_data  (bus_data),
            .bus_rd    (bus_rd),
            .bus_wr    (bus_wr),
            .bus_space (bus_space),
            .ref_val   (ref_val[u]),
            .mask_val  (mask_val[u]),
            .ctrl      (ctrl_val[u]),
            .clr       (flag_clr[u]),
            .evt       (evt[u]),
            .flag      (flag[u])
        );
    end

    bmm_irq_merge #(
        .NUM_UNITS (NUM_UNITS)
    ) u_irq (
        .flag     (flag),
        .ctrl_val (ctrl_val),
        .irq      (irq)
    );

endmodule

// File: rtl/bmm_checker.sv
// Temporal checks on the monitor's outputs, bound to every bus_match_monitor.
// Assumes unit_en is the registered per-unit enable of the top module.
module bmm_checker #(
    parameter int NUM_UNITS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_rd,
    input logic                 bus_wr,
    input logic [NUM_UNITS-1:0] flag_clr,
    input logic [NUM_UNITS-1:0] evt,
    input logic [NUM_UNITS-1:0] flag,
    input logic [NUM_UNITS-1:0] unit_en,
    input logic                 irq
);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_chk
        AST_EVT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[u] |-> $past(bus_rd || bus_wr)); // R3
        AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            evt[u] |-> flag[u]); // R7
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[u] && !flag_clr[u]) |=> flag[u]); // R7
        AST_FLAG_RISE_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[u]) |-> evt[u]); // R7
        AST_OFF_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(unit_en[u]) |-> !evt[u]); // R9
        AST_OFF_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(unit_en[u]) |-> $stable(flag[u])); // R9
    end

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flag)); // R8

endmodule

bind bus_match_monitor bmm_checker #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .flag_clr (flag_clr),
    .evt      (evt),
    .flag     (flag),
    .unit_en  (unit_en),
    .irq      (irq)
);

// File: tb/bus_match_monitor_test.sv
// Self-checking bench: directed corners plus seeded random traffic, checked
// against a cycle model kept in the bench.
module bus_match_monitor_test;

    localparam int NU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_space = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_unit = '0;
    logic [1:0]  cfg_reg = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  flag_clr = '0;
    logic [3:0]  evt, flag;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_ref  [NU];
    logic [31:0] m_mask [NU];
    logic [5:0]  m_ctrl [NU];
    logic [3:0]  m_flag, m_evt;
    logic        m_irq;

    bus_match_monitor uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_space(bus_space),
        .cfg_we(cfg_we), .cfg_unit(cfg_unit), .cfg_reg(cfg_reg),
        .cfg_wdata(cfg_wdata), .flag_clr(flag_clr),
        .evt(evt), .flag(flag), .irq(irq)
    );

    always #10 clk = ~clk;

    // Expected hit of unit i for the given access
    function automatic bit exp_hit(int i, logic [19:0] a, logic [31:0] d,
                                   logic rd, logic wr, logic sp);
        logic [31:0] src;
        src = m_ctrl[i][3] ? d : {12'b0, a};
        return m_ctrl[i][0]
            && (((src ^ m_ref[i]) & ~m_mask[i]) == 32'b0)
            && ((m_ctrl[i][1] && rd) || (m_ctrl[i][2] && wr))
            && (sp == m_ctrl[i][4]);
    endfunction

    task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at falling edge, update model, check at next falling edge
    task automatic step(logic [19:0] a, logic [31:0] d, logic rd, logic wr,
                        logic sp, logic [3:0] clr, logic we, logic [1:0] un,
                        logic [1:0] rg, logic [31:0] wd, string tag);
        logic [3:0] n_evt, n_flag;
        bus_addr = a; bus_data = d; bus_rd = rd; bus_wr = wr; bus_space = sp;
        flag_clr = clr; cfg_we = we; cfg_unit = un; cfg_reg = rg; cfg_wdata = wd;
        for (int i = 0; i < NU; i++) begin
            n_evt[i]  = exp_hit(i, a, d, rd, wr, sp);
            n_flag[i] = m_flag[i];
            if (m_ctrl[i][0]) begin
                if (n_evt[i])    n_flag[i] = 1'b1;
                else if (clr[i]) n_flag[i] = 1'b0;
            end
        end
        if (we) begin
            case (rg)
                2'd0: m_ref[un]  = wd;
                2'd1: m_mask[un] = wd;
                2'd2: m_ctrl[un] = wd[5:0];
                default: ;
            endcase
        end
        m_evt = n_evt; m_flag = n_flag;
        m_irq = 1'b0;
        for (int i = 0; i < NU; i++) if (m_flag[i] && m_ctrl[i][5]) m_irq = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(tag, "evt", evt, m_evt);
        check(tag, "flag", flag, m_flag);
        check(tag, "irq", {3'b0, irq}, {3'b0, m_irq});
    endtask

    task automatic wcfg(logic [1:0] un, logic [1:0] rg, logic [31:0] wd, string tag);
        step('0, '0, 0, 0, 0, '0, 1, un, rg, wd, tag);
    endtask

    task automatic acc(logic [19:0] a, logic [31:0] d, logic rd, logic wr,
                       logic sp, string tag);
        step(a, d, rd, wr, sp, '0, 0, '0, '0, '0, tag);
    endtask

    task automatic idle(logic [3:0] clr, string tag);
        step('0, '0, 0, 0, 0, clr, 0, '0, '0, '0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NU; i++) begin
            m_ref[i] = '0; m_mask[i] = '0; m_ctrl[i] = '0;
        end
        m_flag = '0; m_evt = '0; m_irq = 0;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1", "evt", evt, 4'h0);
        check("R1", "flag", flag, 4'h0);
        check("R1", "irq", {3'b0, irq}, 4'h0);
        rst_n = 1'b1;
        // R1: disabled units ignore a bus access that would match zero reference
        acc(20'h0, 32'h0, 1, 1, 0, "R1");

        // R12: guard band, writes only, irq enabled (ctrl 0x25)
        wcfg(0, 0, 32'h99FF0, "R10");
        wcfg(0, 1, 32'hF, "R10");
        wcfg(0, 2, 32'h25, "R10");
        for (int a = 'h99FEE; a <= 'h9A001; a++) acc(20'(a), 32'h0, 0, 1, 0, "R12");
        idle(4'b0001, "R7");
        // R4: read into the band is not a hit for a write-only unit
        acc(20'h99FF4, 32'h0, 1, 0, 0, "R4");
        // R3: a single hit gives one pulse, then low
        acc(20'h99FF8, 32'h0, 0, 1, 0, "R3");
        idle(4'b0000, "R3");
        // R7: clear together with a hit keeps the flag
        step(20'h99FF1, 32'h0, 0, 1, 0, 4'b0001, 0, 0, 0, 0, "R7");
        idle(4'b0001, "R7");
        // R2: mask bit 4 as don't-care widens the match
        wcfg(0, 1, 32'h1F, "R2");
        acc(20'h99FE3, 32'h0, 0, 1, 0, "R2");
        acc(20'h99FD3, 32'h0, 0, 1, 0, "R2");
        // R8: unit 1 hits with irq disabled (ctrl 0x07)
        idle(4'b0001, "R8");
        wcfg(1, 0, 32'h00100, "R8");
        wcfg(1, 2, 32'h07, "R8");
        acc(20'h00100, 32'h0, 1, 0, 0, "R8");
        // R5: data source, reads only (ctrl 0x0B)
        wcfg(2, 0, 32'hDEADBEEF, "R5");
        wcfg(2, 2, 32'h0B, "R5");
        acc(20'h12345, 32'hDEADBEEF, 1, 0, 0, "R5");
        acc(20'h12345, 32'hDEADBEEE, 1, 0, 0, "R5");
        // R6: space 1, any value, both directions (ctrl 0x17)
        wcfg(3, 1, 32'hFFFFFFFF, "R6");
        wcfg(3, 2, 32'h17, "R6");
        acc(20'h55555, 32'h0, 1, 0, 0, "R6");
        acc(20'h55555, 32'h0, 0, 1, 1, "R6");
        // R9: disable unit 0 while flagged; no event, clear ignored
        acc(20'h99FF0, 32'h0, 0, 1, 0, "R9");
        wcfg(0, 2, 32'h24, "R9");
        acc(20'h99FF0, 32'h0, 0, 1, 0, "R9");
        idle(4'b0001, "R9");
        // R10: same-edge reprogram uses old ref for this access
        wcfg(0, 2, 32'h25, "R10");
        step(20'h99FF2, 32'h0, 0, 1, 0, 4'b0000, 1, 0, 0, 32'h40000, "R10");
        acc(20'h99FF2, 32'h0, 0, 1, 0, "R10");
        acc(20'h40003, 32'h0, 0, 1, 0, "R10");
        // R10: register code 3 is ignored
        wcfg(0, 3, 32'h0, "R10");
        acc(20'h40001, 32'h0, 0, 1, 0, "R10");
        // R11: seeded random traffic over all units
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] pool [4];
            logic [19:0] a;
            pool[0] = 32'h99FF0; pool[1] = 32'h00100; pool[2] = 32'h40000; pool[3] = 32'h1FFF0;
            if ($urandom_range(0, 9) == 0) begin
                logic [1:0] rg;
                logic [31:0] wd;
                rg = 2'($urandom_range(0, 3));
                case (rg)
                    2'd0: wd = pool[$urandom_range(0, 3)];
                    2'd1: wd = (32'h1 << $urandom_range(0, 6)) - 32'h1;
                    default: wd = $urandom & 32'h3F;
                endcase
                step(20'(pool[$urandom_range(0, 3)]), $urandom, 1'($urandom), 1'($urandom),
                     1'($urandom), 4'($urandom), 1, 2'($urandom), rg, wd, "R11");
            end else begin
                a = 20'(pool[$urandom_range(0, 3)]) + 20'($urandom_range(0, 40)) - 20'd8;
                step(a, $urandom_range(0, 3) == 0 ? 32'hDEADBEEF : $urandom,
                     1'($urandom), 1'($urandom), 1'($urandom),
                     ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0,
                     0, 0, 0, 0, "R11");
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule